// File: doc/BRIEF.md
# RGB to YCbCr 4:2:2 Encoder

This block is a streaming video pipeline stage placed in front of an external HDMI transmitter that takes 16 data lines. Each clock it accepts one 24-bit pixel with 8 bits per colour, together with horizontal sync, vertical sync and data enable, all active high. It converts the pixel to limited-range YCbCr using fixed-point BT.709 weights held with 8 fractional bits. It then halves chroma resolution along the line, so the 8-bit chroma lane carries Cb and Cr on alternate pixels while every pixel keeps its own luma.

The colour lanes of the input word are packed red, blue, green from the most significant byte down. The chroma sent for a pixel pair is the rounded mean of the two pixels' samples, which needs one pixel of look-ahead. Sync and enable are delayed by the same fixed three clocks as the data. Outside active video the data bus holds the blanking code. The output runs at one word per pixel clock, with no double data rate.

Top module: `ycc422_encoder`

## Requirements
- R1: The input lanes are pix_in[23:16] = red, pix_in[15:8] = blue and pix_in[7:0] = green, each an unsigned 8-bit value.
- R2: Luma is Y = clamp(floor((47·R + 157·G + 16·B + 16·256 + 128) / 256), 16, 235).
- R3: The chroma samples are Cb = clamp(floor((−26·R − 86·G + 112·B + 128·256 + 128) / 256), 16, 240) and Cr = clamp(floor((112·R − 102·G − 10·B + 128·256 + 128) / 256), 16, 240).
- R4: For an active pixel, yc_out[15:8] is that pixel's own luma and yc_out[7:0] is the chroma code for its slot.
- R5: The first active pixel after a clock with de_in low takes the Cb slot. Later active pixels alternate Cr, Cb, Cr and so on until de_in drops.
- R6: A Cb slot carries (Cb_self + Cb_next + 1) >> 1, where next is the following pixel. A Cr slot carries (Cr_prev + Cr_self + 1) >> 1, where prev is the pixel before it.
- R7: A pixel in a Cb slot whose following clock has de_in low carries its own Cb, with no averaging.
- R8: hs_out, vs_out and de_out equal hs_in, vs_in and de_in of exactly 3 clocks earlier. The data for a pixel appears in the same clock as its de_out.
- R9: While de_out is low, yc_out is 16'h1080 (luma 16, chroma 128), whatever pix_in held.
- R10: While rst_n is low, yc_out is 16'h1080 and hs_out, vs_out and de_out are 0, whatever the inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_in | input | 24 | Pixel, lanes red/blue/green from the top byte down |
| hs_in | input | 1 | Horizontal sync, active high |
| vs_in | input | 1 | Vertical sync, active high |
| de_in | input | 1 | Active video enable |
| yc_out | output | 16 | Luma in the upper byte, alternating chroma in the lower byte |
| hs_out | output | 1 | Horizontal sync, aligned to yc_out |
| vs_out | output | 1 | Vertical sync, aligned to yc_out |
| de_out | output | 1 | Enable, aligned to yc_out |

## Verification
A slip in the chroma phase register swaps Cb and Cr within a pair. That shows on the lower byte of the second word of the next active line, three clocks after the pixel enters. A stale look-ahead value or held Cr corrupts only the chroma byte of the pair it belongs to, while luma stays correct. Any skew between the data pipe and the sync delay line shows as a blank word with de_out high, or as colour data with de_out low, at the first edge of a line. Lines of odd length and one-clock gaps in enable are therefore the stimuli that expose these faults fastest.

// File: rtl/ycc_pkg.sv
`timescale 1ns/1ps
package ycc_pkg;
  localparam int unsigned CW   = 8;            // bits per component
  localparam int unsigned FRAC = 8;            // fractional bits of weights
  localparam int unsigned AW   = 2*CW + 4;     // accumulator width
  localparam int unsigned LAT  = 3;            // pipeline latency in clocks
  localparam int unsigned HALF = 1 << (FRAC-1);

  localparam int Y_OFS = 16;
  localparam int C_OFS = 128;
  localparam int Y_MIN = 16;
  localparam int Y_MAX = 235;
  localparam int C_MIN = 16;
  localparam int C_MAX = 240;

  // BT.709 limited-range weights scaled by 2**FRAC
  localparam int KY_R = 47,  KY_G = 157,  KY_B = 16;
  localparam int KB_R = -26, KB_G = -86,  KB_B = 112;
  localparam int KR_R = 112, KR_G = -102, KR_B = -10;

  typedef logic [CW-1:0]        comp_t;
  typedef logic signed [AW-1:0] acc_t;

  typedef struct packed {
    acc_t y;
    acc_t cb;
    acc_t cr;
  } acc3_t;

  typedef struct packed {
    comp_t y;
    comp_t cb;
    comp_t cr;
  } ycc_t;

  localparam logic [2*CW-1:0] BLANK = {comp_t'(Y_OFS), comp_t'(C_OFS)};

  function automatic acc_t mac3(int kr, int kg, int kb, int ofs,
                                comp_t r, comp_t g, comp_t b);
    int s;
    s = kr*int'(r) + kg*int'(g) + kb*int'(b) + (ofs << FRAC) + int'(HALF);
    return acc_t'(s);
  endfunction

  function automatic comp_t clip(acc_t a, int lo, int hi);
    int s;
    s = int'(a >>> FRAC);
    if (s < lo)      s = lo;
    else if (s > hi) s = hi;
    return comp_t'(s);
  endfunction

  function automatic comp_t mean2(comp_t a, comp_t b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b} + (CW+1)'(1);
    return s[CW:1];
  endfunction
endpackage

// File: rtl/ycc_rst_sync.sv
`timescale 1ns/1ps
module ycc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sh_q, sh_n;

  always_comb sh_n = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign rst_q_n = sh_q[STAGES-1];
endmodule

// File: rtl/ycc_sync_delay.sv
`timescale 1ns/1ps
module ycc_sync_delay #(
  parameter int unsigned W     = 3,
  parameter int unsigned DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    logic [W-1:0] q_r;
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= g_stg[i-1].q_r;
      end
    end
  end

  assign q = g_stg[DEPTH-1].q_r;
endmodule

// File: rtl/ycc_matrix.sv
`timescale 1ns/1ps
module ycc_matrix
  import ycc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3*CW-1:0] pix_i,
  input  logic            de_i,
  output acc3_t           acc_o,
  output logic            de_o,
  output logic            ph_o
);
  comp_t r, g, b;
  acc3_t acc_n;
  logic  run_q, run_n;   // phase of the next active pixel

  // lanes packed red, blue, green from the top
  assign r = pix_i[3*CW-1:2*CW];
  assign b = pix_i[2*CW-1:CW];
  assign g = pix_i[CW-1:0];

  always_comb begin
    acc_n.y  = mac3(KY_R, KY_G, KY_B, Y_OFS, r, g, b);
    acc_n.cb = mac3(KB_R, KB_G, KB_B, C_OFS, r, g, b);
    acc_n.cr = mac3(KR_R, KR_G, KR_B, C_OFS, r, g, b);
    run_n    = de_i ? ~run_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o <= '0;
      de_o  <= 1'b0;
      ph_o  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      acc_o <= acc_n;
      de_o  <= de_i;
      ph_o  <= run_q;
      run_q <= run_n;
    end
  end
endmodule

// File: rtl/ycc_pack.sv
`timescale 1ns/1ps
module ycc_pack
  import ycc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  acc3_t           acc_i,
  input  logic            de_i,
  input  logic            ph_i,
  output logic [2*CW-1:0] word_o
);
  ycc_t  cur, s2_q, s2_n;
  logic  de2_q, de2_n, ph2_q, ph2_n;
  comp_t crh_q, crh_n;
  comp_t avg_cb, avg_cr;
  logic [2*CW-1:0] word_n;

  // clamp of the pixel one step behind s2 (the look-ahead partner)
  always_comb begin
    cur.y  = clip(acc_i.y,  Y_MIN, Y_MAX);
    cur.cb = clip(acc_i.cb, C_MIN, C_MAX);
    cur.cr = clip(acc_i.cr, C_MIN, C_MAX);
  end

  assign avg_cb = mean2(s2_q.cb, cur.cb);
  assign avg_cr = mean2(s2_q.cr, cur.cr);

  always_comb begin
    s2_n   = cur;
    de2_n  = de_i;
    ph2_n  = ph_i;
    crh_n  = crh_q;
    word_n = BLANK;
    if (de2_q) begin
      if (!ph2_q) begin
        word_n = {s2_q.y, de_i ? avg_cb : s2_q.cb};
        crh_n  = avg_cr;
      end else begin
        word_n = {s2_q.y, crh_q};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_q   <= '0;
      de2_q  <= 1'b0;
      ph2_q  <= 1'b0;
      crh_q  <= comp_t'(C_OFS);
      word_o <= BLANK;
    end else begin
      s2_q   <= s2_n;
      de2_q  <= de2_n;
      ph2_q  <= ph2_n;
      crh_q  <= crh_n;
      word_o <= word_n;
    end
  end
endmodule

// File: rtl/ycc422_encoder.sv
`timescale 1ns/1ps
module ycc422_encoder
  import ycc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] pix_in,
  input  logic        hs_in,
  input  logic        vs_in,
  input  logic        de_in,
  output logic [15:0] yc_out,
  output logic        hs_out,
  output logic        vs_out,
  output logic        de_out
);
  logic  rst_q_n;
  acc3_t acc1;
  logic  de1, ph1;
  logic [2:0] sync_q;

  ycc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  ycc_matrix u_mtx (
    .clk(clk), .rst_n(rst_q_n), .pix_i(pix_in), .de_i(de_in),
    .acc_o(acc1), .de_o(de1), .ph_o(ph1)
  );

  ycc_pack u_pack (
    .clk(clk), .rst_n(rst_q_n), .acc_i(acc1), .de_i(de1), .ph_i(ph1),
    .word_o(yc_out)
  );

  ycc_sync_delay #(.W(3), .DEPTH(LAT)) u_dly (
    .clk(clk), .rst_n(rst_q_n), .d({hs_in, vs_in, de_in}), .q(sync_q)
  );

  assign {hs_out, vs_out, de_out} = sync_q;
endmodule

// File: rtl/ycc422_encoder_chk.sv
`timescale 1ns/1ps
module ycc422_encoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hs_in,
  input logic        vs_in,
  input logic        de_in,
  input logic [15:0] yc_out,
  input logic        hs_out,
  input logic        vs_out,
  input logic        de_out
);
  logic [2:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                warm_cnt <= '0;
    else if (warm_cnt != 3'd7) warm_cnt <= warm_cnt + 3'd1;
  end
  assign warm = (warm_cnt == 3'd7);

  assert_blank_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !de_out |-> yc_out == 16'h1080);

  assert_luma_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    de_out |-> (yc_out[15:8] >= 8'd16 && yc_out[15:8] <= 8'd235));

  assert_chroma_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    de_out |-> (yc_out[7:0] >= 8'd16 && yc_out[7:0] <= 8'd240));

  assert_de_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> de_out == $past(de_in, 3));

  assert_hs_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> hs_out == $past(hs_in, 3));

  assert_vs_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> vs_out == $past(vs_in, 3));
endmodule

bind ycc422_encoder ycc422_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
  .yc_out(yc_out), .hs_out(hs_out), .vs_out(vs_out), .de_out(de_out)
);

// File: tb/ycc422_encoder_bench.sv
`timescale 1ns/1ps
module ycc422_encoder_bench;
  localparam int NB = 48;

  logic        clk;
  logic        rst_n;
  logic [23:0] pix_in;
  logic        hs_in, vs_in, de_in;
  logic [15:0] yc_out;
  logic        hs_out, vs_out, de_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [23:0] s_pix [NB];
  logic        s_de  [NB];
  logic        s_hs  [NB];
  logic        s_vs  [NB];
  logic [15:0] o_yc  [NB];
  logic [2:0]  o_syn [NB];

  ycc422_encoder u_ycc422_encoder (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .hs_in(hs_in), .vs_in(vs_in),
    .de_in(de_in), .yc_out(yc_out), .hs_out(hs_out), .vs_out(vs_out),
    .de_out(de_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- reference model from the requirements ----------------
  function automatic int clampi(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int ry(logic [23:0] p);
    int r, g, b;
    r = int'(p[23:16]); b = int'(p[15:8]); g = int'(p[7:0]);
    return clampi((47*r + 157*g + 16*b + 4096 + 128) >>> 8, 16, 235);
  endfunction

  function automatic int rcb(logic [23:0] p);
    int r, g, b;
    r = int'(p[23:16]); b = int'(p[15:8]); g = int'(p[7:0]);
    return clampi((-26*r - 86*g + 112*b + 32768 + 128) >>> 8, 16, 240);
  endfunction

  function automatic int rcr(logic [23:0] p);
    int r, g, b;
    r = int'(p[23:16]); b = int'(p[15:8]); g = int'(p[7:0]);
    return clampi((112*r - 102*g - 10*b + 32768 + 128) >>> 8, 16, 240);
  endfunction

  function automatic logic [15:0] model(int j, int n);
    int k, c;
    if (!s_de[j]) return 16'h1080;
    k = j;
    while (k > 0 && s_de[k-1]) k--;
    if (((j - k) % 2) == 0) begin
      if (j + 1 < n && s_de[j+1]) c = (rcb(s_pix[j]) + rcb(s_pix[j+1]) + 1) >> 1;
      else                        c = rcb(s_pix[j]);
    end else begin
      c = (rcr(s_pix[j-1]) + rcr(s_pix[j]) + 1) >> 1;
    end
    return {8'(ry(s_pix[j])), 8'(c)};
  endfunction

  // ---------------- helpers ----------------
  task automatic check16(string req, string what, logic [15:0] got, logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic clear_stream();
    for (int j = 0; j < NB; j++) begin
      s_pix[j] = '0; s_de[j] = 0; s_hs[j] = 0; s_vs[j] = 0;
    end
  endtask

  task automatic put(int j, logic [23:0] p, logic de, logic hs, logic vs);
    s_pix[j] = p; s_de[j] = de; s_hs[j] = hs; s_vs[j] = vs;
  endtask

  // drive beats at falling edges; output of beat j is visible 3 falls later
  task automatic run_stream(int n);
    for (int j = 0; j < n + 3; j++) begin
      @(negedge clk);
      if (j >= 3) begin
        o_yc[j-3]  = yc_out;
        o_syn[j-3] = {hs_out, vs_out, de_out};
      end
      if (j < n) begin
        pix_in = s_pix[j]; de_in = s_de[j]; hs_in = s_hs[j]; vs_in = s_vs[j];
      end else begin
        pix_in = 24'h5A5A5A; de_in = 0; hs_in = 0; vs_in = 0;
      end
    end
  endtask

  task automatic check_stream(string req, int n);
    for (int j = 0; j < n; j++) begin
      check16(req, $sformatf("data beat %0d", j), o_yc[j], model(j, n));
      check16("R8", $sformatf("sync beat %0d", j), {13'd0, o_syn[j]},
              {13'd0, s_hs[j], s_vs[j], s_de[j]});
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 0; pix_in = 24'hFFFFFF; de_in = 1; hs_in = 1; vs_in = 1;
    repeat (3) @(negedge clk);
    check16("R10", "yc_out in reset", yc_out, 16'h1080);
    check16("R10", "sync in reset", {13'd0, hs_out, vs_out, de_out}, 16'd0);
    de_in = 0; hs_in = 0; vs_in = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_primaries();
    logic [23:0] cols [6];
    cols = '{24'hFF0000, 24'h00FF00, 24'h0000FF, 24'hFFFFFF, 24'h000000, 24'h808080};
    clear_stream();
    for (int i = 0; i < 6; i++) begin
      put(2*i, cols[i], 1, 0, 0);
      put(2*i+1, cols[i], 1, 0, 0);
    end
    run_stream(12);
    // R1 lane order: red in the top byte gives Y 63, Cb 102, Cr 240
    check16("R1", "red Cb word", o_yc[0], 16'h3F66);
    check16("R1", "red Cr word", o_yc[1], 16'h3FF0);
    // blue sits in the middle byte: Y 32
    check16("R1", "blue luma", {8'd0, o_yc[2][15:8]}, 16'd32);
    // white and black hit the luma limits
    check16("R2", "white luma", {8'd0, o_yc[6][15:8]}, 16'd235);
    check16("R2", "black luma", {8'd0, o_yc[8][15:8]}, 16'd16);
    check_stream("R2,R3,R4", 12);
  endtask

  task automatic t_pairs_avg();
    clear_stream();
    put(0, 24'hFF0000, 1, 0, 0);  // red
    put(1, 24'h00FF00, 1, 0, 0);  // blue
    put(2, 24'h0000FF, 1, 0, 0);  // green
    put(3, 24'hFFFFFF, 1, 0, 0);
    put(4, 24'h123456, 1, 0, 0);
    put(5, 24'hC8A032, 1, 0, 0);
    put(6, 24'h3C7F01, 1, 0, 0);
    put(7, 24'hE00F90, 1, 0, 0);
    run_stream(8);
    // R6 hand value: Cb (102+240+1)>>1 = 171, Cr (240+118+1)>>1 = 179
    check16("R6", "red/blue Cb avg", o_yc[0], 16'h3FAB);
    check16("R6", "red/blue Cr avg", o_yc[1], 16'h20B3);
    check_stream("R6", 8);
  endtask

  task automatic t_phase();
    clear_stream();
    put(0, 24'hFF0000, 1, 0, 0);
    put(1, 24'h00FF00, 1, 0, 0);
    put(2, 24'hFF0000, 1, 0, 0);  // lone Cb slot
    put(3, 24'h777777, 0, 1, 0);
    put(4, 24'h00FF00, 1, 0, 0);  // phase restarts: Cb slot
    put(5, 24'hFF0000, 1, 0, 0);
    put(6, 24'h000000, 0, 0, 0);
    put(7, 24'h000000, 0, 0, 0);
    put(8, 24'h0000FF, 1, 0, 0);  // single pixel line
    run_stream(9);
    check16("R7", "lone red keeps own Cb", o_yc[2], 16'h3F66);
    // blue then red: Cb avg (240+102+1)>>1 = 171 in the first slot
    check16("R5", "phase restart slot Cb", o_yc[4], 16'h20AB);
    check16("R5", "phase restart slot Cr", o_yc[5], 16'h3FB3);
    check_stream("R5,R7", 9);
  endtask

  task automatic t_sync();
    clear_stream();
    for (int j = 0; j < 20; j++)
      put(j, 24'(j * 24'h0B1D07), (j % 7) > 1, (j % 5) == 0, (j % 3) == 1);
    run_stream(20);
    check_stream("R8", 20);
  endtask

  task automatic t_blank();
    clear_stream();
    for (int j = 0; j < 10; j++) put(j, 24'hF0E1D2 ^ 24'(j), 0, j[0], j[1]);
    run_stream(10);
    for (int j = 0; j < 10; j++)
      check16("R9", $sformatf("blank beat %0d", j), o_yc[j], 16'h1080);
    check_stream("R9", 10);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_primaries();
    t_pairs_avg();
    t_phase();
    t_sync();
    t_blank();
    finish_run();
  end
endmodule